// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is the serial configuration port of a clock-distribution device. It listens on a two-wire SMBus/I2C-style bus and answers one of two device addresses, picked by a strap input. It holds a small bank of byte-wide control registers whose bits drive the device's output-enable lines directly. Because every register comes out of reset holding its default value, the device runs correctly if no serial access is ever made.

After the address, the controller sends a command byte. Bit 7 of that byte chooses between two kinds of access. A single-byte access reaches the register whose offset is in bits 4:0. A block access walks the registers upward from the first one. Bits 6:5 of the command must match a value set by a chip-select strap, so several devices can share one bus address. The open-drain data line is modelled as a bus input `sdaIn` and a pull-low enable `sdaOe`. The clock line is input only, because the slave never stretches it. Both bus inputs pass through two-flop synchronizers, and the block works from their edges in the system clock domain.

Top module: `smbus_cfg_slave`

## Requirements
- R1: After reset, every register holds 0xFF, so all enable outputs are 1, and `sdaOe` is 0.
- R2: The write address is 0xD2 when `addrSel` is 0 and 0xDC when it is 1. The slave ACKs its write address by pulling SDA low during the 9th clock. Any other first byte is NACKed, and SDA stays released until the next start.
- R3: The command is acted on only if bits 6:5 equal 01 when `chipSel` is 0, or 10 when `chipSel` is 1. If they do not match, the command is NACKed and the bytes that follow change no register.
- R4: A command with bit 7 = 1 is a single-byte access at the offset in bits 4:0. A write byte that follows is stored in that register and ACKed. Register k drives `enables[8k+7:8k]`.
- R5: For a single-byte read, the controller sends a repeated start and then the read address (write address with bit 0 set). The slave then returns the addressed register, MSB first.
- R6: A command with bit 7 = 0 is a block access starting at register 0. In a block write, the byte after the command is a count and is ACKed but ignored. Data bytes then go to registers 0, 1, 2 and so on. A stop after any whole byte keeps the bytes already written.
- R7: A block read returns the register count (8) first, then registers from 0 upward for as long as the controller ACKs. A NACK ends the transfer.
- R8: Offsets of 8 or more, whether given directly or reached by a block access, ignore writes (which are still ACKed) and read as 0x00.
- R9: A repeated start returns the slave to the address phase and drops any access in progress. A stop releases SDA.
- R10: The read address is NACKed unless the most recent command byte matched the chip-select field. No command has matched since reset until one does.
- R11: `sdaOe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level, as seen on the bus |
| sdaOe | output | 1 | 1 pulls the data line low |
| addrSel | input | 1 | Strap that picks the device address 0xD2 or 0xDC |
| chipSel | input | 1 | Strap that picks the required command field 01 or 10 |
| enables | output | NUM_REGS*8 | Register bank contents, register 0 in the low byte |

## Verification
Each bus input reaches the control logic two cycles after it changes, and edge detection adds one more register. So `sdaOe` responds, and a written register updates, within four clock cycles of the SCL fall that ends the relevant bit. The bench holds each SCL phase for eight cycles. It samples ACK and read data at the midpoint of SCL high, which is well after the slave's drive has settled. It compares the enable outputs only after the stop condition has been sent, when every write has long since landed. A monitor that runs all the time flags any change of `sdaOe` once SCL has been high for more than four cycles.

// File: rtl/smbus_cfg_pkg.sv
`timescale 1ns/1ps
package smbus_cfg_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK} busState_t;
  typedef enum logic [1:0] {PH_ADDR, PH_CMD, PH_COUNT, PH_DATA} phase_t;

  // strobes from the sequencer to the byte datapath
  typedef struct packed {
    logic rxShift;     // shift rxBit into the receive byte
    logic rxBit;
    logic cmdLoad;     // latch pointer from a matched command byte
    logic regWrite;    // store receive byte at pointer, advance pointer
    logic txLoadCount; // load register count into transmit byte
    logic txLoadData;  // load register at pointer, advance pointer
    logic txShift;     // next transmit bit
  } dpStrobe_t;
endpackage

// File: rtl/smbus_cfg_dp.sv
`timescale 1ns/1ps
module smbus_cfg_dp
  import smbus_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter logic [7:0] RST_VALUE = 8'hFF
) (
  input  logic clk,
  input  logic rstN,
  input  dpStrobe_t stb,
  output logic [7:0] rxByte,
  output logic txMsb,
  output logic [NUM_REGS*8-1:0] enables
);
  localparam int OFFS_W = 5;
  localparam int PTR_W = OFFS_W + 1;
  localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);

  logic [NUM_REGS*8-1:0] bankQ;
  logic [PTR_W-1:0] ptrQ;
  logic [7:0] rxSh, txSh, readVal;

  // out-of-range pointer reads as zero
  always_comb begin
    readVal = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (ptrQ == PTR_W'(i)) readVal = bankQ[i*8 +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ <= {NUM_REGS{RST_VALUE}};
    end else if (stb.regWrite) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (ptrQ == PTR_W'(i)) bankQ[i*8 +: 8] <= rxSh;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
      rxSh <= '0;
      txSh <= '0;
    end else begin
      if (stb.rxShift) rxSh <= {rxSh[6:0], stb.rxBit};
      if (stb.cmdLoad)
        ptrQ <= rxSh[7] ? {1'b0, rxSh[OFFS_W-1:0]} : '0;
      else if ((stb.regWrite || stb.txLoadData) && ptrQ != '1)
        ptrQ <= ptrQ + 1'b1;
      if (stb.txLoadCount) txSh <= COUNT_BYTE;
      else if (stb.txLoadData) txSh <= readVal;
      else if (stb.txShift) txSh <= {txSh[6:0], 1'b0};
    end
  end

  assign rxByte = rxSh;
  assign txMsb = txSh[7];
  assign enables = bankQ;
endmodule

// File: rtl/smbus_cfg_ctrl.sv
`timescale 1ns/1ps
module smbus_cfg_ctrl
  import smbus_cfg_pkg::*;
#(
  parameter logic [7:0] ADDR_LO = 8'hD2,
  parameter logic [7:0] ADDR_HI = 8'hDC
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclS,
  input  logic sdaS,
  input  logic addrSel,
  input  logic chipSel,
  input  logic [7:0] rxByte,
  input  logic txMsb,
  output dpStrobe_t stb,
  output logic sdaOe
);
  busState_t stateQ;
  phase_t phaseQ;
  logic [3:0] bitCnt;
  logic sclQ, sdaQ, ackDrive, goTx, blockMode, cmdOk, mAck;

  logic sclRise, sclFall, startDet, stopDet, isEval;
  logic [7:0] devAddr;
  logic [1:0] csField;
  logic addrWr, addrRd, csMatch, ackNow;

  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;
  assign devAddr  = addrSel ? ADDR_HI : ADDR_LO;
  assign csField  = chipSel ? 2'b10 : 2'b01;
  assign addrWr   = rxByte == {devAddr[7:1], 1'b0};
  assign addrRd   = (rxByte == {devAddr[7:1], 1'b1}) && cmdOk;
  assign csMatch  = rxByte[6:5] == csField;
  assign isEval   = stateQ == ST_RX && sclFall && bitCnt == 4'd8;

  always_comb begin
    case (phaseQ)
      PH_ADDR: ackNow = addrWr | addrRd;
      PH_CMD:  ackNow = csMatch;
      default: ackNow = 1'b1;
    endcase
  end

  always_comb begin
    stb = '0;
    stb.rxBit = sdaS;
    if (!startDet && !stopDet) begin
      case (stateQ)
        ST_RX: begin
          stb.rxShift  = sclRise && bitCnt != 4'd8;
          stb.cmdLoad  = isEval && phaseQ == PH_CMD && csMatch;
          stb.regWrite = isEval && phaseQ == PH_DATA;
        end
        ST_RXACK: begin
          stb.txLoadCount = sclFall && goTx && blockMode;
          stb.txLoadData  = sclFall && goTx && !blockMode;
        end
        ST_TX:    stb.txShift = sclFall && bitCnt != 4'd7;
        ST_TXACK: stb.txLoadData = sclFall && mAck;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
      stateQ <= ST_IDLE;
      phaseQ <= PH_ADDR;
      bitCnt <= '0;
      ackDrive <= 1'b0;
      goTx <= 1'b0;
      blockMode <= 1'b0;
      cmdOk <= 1'b0;
      mAck <= 1'b0;
    end else begin
      sclQ <= sclS;
      sdaQ <= sdaS;
      if (startDet) begin
        stateQ <= ST_RX;
        phaseQ <= PH_ADDR;
        bitCnt <= '0;
        ackDrive <= 1'b0;
      end else if (stopDet) begin
        stateQ <= ST_IDLE;
        ackDrive <= 1'b0;
      end else begin
        case (stateQ)
          ST_RX: begin
            if (sclRise && bitCnt != 4'd8) bitCnt <= bitCnt + 1'b1;
            if (isEval) begin
              bitCnt <= '0;
              ackDrive <= ackNow;
              stateQ <= ackNow ? ST_RXACK : ST_IDLE;
              goTx <= phaseQ == PH_ADDR && !addrWr && addrRd;
              case (phaseQ)
                PH_ADDR: phaseQ <= PH_CMD;
                PH_CMD: begin
                  cmdOk <= csMatch;
                  if (csMatch) begin
                    blockMode <= ~rxByte[7];
                    phaseQ <= rxByte[7] ? PH_DATA : PH_COUNT;
                  end
                end
                default: phaseQ <= PH_DATA;
              endcase
            end
          end
          ST_RXACK: if (sclFall) begin
            ackDrive <= 1'b0;
            bitCnt <= '0;
            stateQ <= goTx ? ST_TX : ST_RX;
          end
          ST_TX: if (sclFall) begin
            if (bitCnt == 4'd7) begin
              stateQ <= ST_TXACK;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_TXACK: begin
            if (sclRise) mAck <= ~sdaS;
            if (sclFall) stateQ <= mAck ? ST_TX : ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaOe = ackDrive | (stateQ == ST_TX && !txMsb);
endmodule

// File: rtl/smbus_cfg_slave.sv
`timescale 1ns/1ps
module smbus_cfg_slave
  import smbus_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter logic [7:0] RST_VALUE = 8'hFF,
  parameter logic [7:0] ADDR_LO = 8'hD2,
  parameter logic [7:0] ADDR_HI = 8'hDC
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe,
  input  logic addrSel,
  input  logic chipSel,
  output logic [NUM_REGS*8-1:0] enables
);
  logic [1:0] sclPipe, sdaPipe;
  logic sclSync, sdaSync, txMsb;
  logic [7:0] rxByte;
  dpStrobe_t stb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= 2'b11;
      sdaPipe <= 2'b11;
    end else begin
      sclPipe <= {sclPipe[0], sclIn};
      sdaPipe <= {sdaPipe[0], sdaIn};
    end
  end
  assign sclSync = sclPipe[1];
  assign sdaSync = sdaPipe[1];

  smbus_cfg_ctrl #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclSync), .sdaS(sdaSync),
    .addrSel(addrSel), .chipSel(chipSel), .rxByte(rxByte),
    .txMsb(txMsb), .stb(stb), .sdaOe(sdaOe)
  );

  smbus_cfg_dp #(.NUM_REGS(NUM_REGS), .RST_VALUE(RST_VALUE)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rxByte(rxByte),
    .txMsb(txMsb), .enables(enables)
  );
endmodule

// File: rtl/smbus_cfg_checker.sv
`timescale 1ns/1ps
module smbus_cfg_checker #(
  parameter int NUM_REGS = 8,
  parameter logic [7:0] RST_VALUE = 8'hFF
) (
  input logic clk,
  input logic rstN,
  input logic sclSync,
  input logic sdaSync,
  input logic sdaOe,
  input logic [NUM_REGS*8-1:0] enables
);
  a_r1_reset_defaults: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (enables == {NUM_REGS{RST_VALUE}}));

  a_r11_oe_quiet_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclSync && $past(sclSync)) |-> $stable(sdaOe));

  // R4: register updates land only in the SCL low phase
  a_r4_write_in_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(enables) |-> !sclSync);

  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    (sclSync && $past(sclSync) && $rose(sdaSync)) |=> !sdaOe);
endmodule

bind smbus_cfg_slave smbus_cfg_checker #(.NUM_REGS(NUM_REGS), .RST_VALUE(RST_VALUE)) u_chk (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .sdaSync(sdaSync),
  .sdaOe(sdaOe), .enables(enables)
);

// File: tb/smbus_cfg_slave_test.sv
`timescale 1ns/1ps
module smbus_cfg_slave_test;
  localparam int NREG = 8;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1;
  logic mSda = 1'b1;
  logic addrSel = 1'b0;
  logic chipSel = 1'b0;
  logic sdaOe;
  logic sdaIn;
  logic [NREG*8-1:0] enables;

  int nChecks = 0, nFail = 0, oeViol = 0, highCnt = 0;
  logic prevOe = 1'b0;
  logic [7:0] model [NREG];
  bit cmdOkModel = 0;

  always #2.5 clk = ~clk;
  assign sdaIn = mSda & ~sdaOe;

  smbus_cfg_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaOe(sdaOe),
    .addrSel(addrSel), .chipSel(chipSel), .enables(enables)
  );

  // R11 monitor: no change of the pull-down once SCL has settled high
  always @(negedge clk) begin
    if (sclIn) highCnt++; else highCnt = 0;
    if (rstN && highCnt > 4 && sdaOe !== prevOe) oeViol++;
    prevOe = sdaOe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] devAddr();
    return addrSel ? 8'hDC : 8'hD2;
  endfunction

  function automatic logic [1:0] csBits();
    return chipSel ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [7:0] expRead(input int idx);
    return (idx < NREG) ? model[idx] : 8'h00;
  endfunction

  task automatic busStart();
    mSda = 1'b1; tick(HALF);
    sclIn = 1'b1; tick(HALF);
    mSda = 1'b0; tick(HALF);
    sclIn = 1'b0; tick(HALF);
  endtask

  task automatic busStop();
    mSda = 1'b0; tick(HALF);
    sclIn = 1'b1; tick(HALF);
    mSda = 1'b1; tick(HALF);
  endtask

  task automatic putByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; tick(HALF);
      sclIn = 1'b1; tick(HALF);
      sclIn = 1'b0;
    end
    mSda = 1'b1; tick(HALF);
    sclIn = 1'b1; tick(HALF/2);
    ack = !sdaIn; tick(HALF/2);
    sclIn = 1'b0;
  endtask

  task automatic getByte(input bit ackIt, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HALF);
      sclIn = 1'b1; tick(HALF/2);
      b[i] = sdaIn; tick(HALF/2);
      sclIn = 1'b0;
    end
    mSda = !ackIt; tick(HALF);
    sclIn = 1'b1; tick(HALF);
    sclIn = 1'b0;
  endtask

  task automatic checkRegs(input string tag);
    for (int i = 0; i < NREG; i++) check(tag, enables[i*8 +: 8], model[i]);
  endtask

  // R3 R4 R8: single-byte write with a given command byte
  task automatic byteWrite(input logic [7:0] cmd, input logic [7:0] data, input string tag);
    logic a;
    bit csOk;
    csOk = cmd[6:5] == csBits();
    busStart();
    putByte(devAddr(), a); check({tag, " R2 addr ack"}, a, 1);
    putByte(cmd, a); check({tag, " R3 cmd ack"}, a, csOk);
    cmdOkModel = csOk;
    putByte(data, a); check({tag, " R4 data ack"}, a, csOk);
    if (csOk && cmd[4:0] < NREG) model[cmd[4:0]] = data;
    busStop();
    checkRegs({tag, " regs"});
  endtask

  // R5 R10: single-byte read
  task automatic byteRead(input logic [7:0] cmd, input string tag);
    logic a;
    logic [7:0] b;
    bit csOk;
    csOk = cmd[6:5] == csBits();
    busStart();
    putByte(devAddr(), a); check({tag, " R2 addr ack"}, a, 1);
    putByte(cmd, a); check({tag, " R3 cmd ack"}, a, csOk);
    cmdOkModel = csOk;
    busStart();
    putByte(devAddr() | 8'h01, a); check({tag, " R10 read addr ack"}, a, csOk);
    if (a) begin
      getByte(1'b0, b); check({tag, " R5 data"}, b, expRead(cmd[4:0]));
    end
    busStop();
  endtask

  // R6 R8: block write of n bytes
  task automatic blockWrite(input int n, input string tag);
    logic a;
    logic [7:0] d;
    busStart();
    putByte(devAddr(), a); check({tag, " R2 addr ack"}, a, 1);
    putByte({1'b0, csBits(), 5'd0}, a); check({tag, " R6 cmd ack"}, a, 1);
    cmdOkModel = 1;
    putByte(8'(n), a); check({tag, " R6 count ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom());
      putByte(d, a); check({tag, " R6 data ack"}, a, 1);
      if (k < NREG) model[k] = d;
    end
    busStop();
    checkRegs({tag, " R6 regs"});
  endtask

  // R7 R8: block read of n data bytes
  task automatic blockRead(input int n, input string tag);
    logic a;
    logic [7:0] b;
    busStart();
    putByte(devAddr(), a); check({tag, " R2 addr ack"}, a, 1);
    putByte({1'b0, csBits(), 5'd0}, a); check({tag, " R7 cmd ack"}, a, 1);
    cmdOkModel = 1;
    busStart();
    putByte(devAddr() | 8'h01, a); check({tag, " R7 read addr ack"}, a, 1);
    getByte(n > 0, b); check({tag, " R7 count"}, b, NREG);
    for (int k = 0; k < n; k++) begin
      getByte(k < n - 1, b); check({tag, " R7 data"}, b, expRead(k));
    end
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] b;
    for (int i = 0; i < NREG; i++) model[i] = 8'hFF;
    void'($urandom(32'd20250611));
    tick(6);
    rstN = 1'b1;
    tick(4);

    // R1 reset state
    check("R1 sdaOe after reset", sdaOe, 0);
    checkRegs("R1 reset regs");

    // R2 foreign address ignored
    busStart();
    putByte(8'hA0, a); check("R2 foreign addr nack", a, 0);
    putByte(8'h85, a); check("R2 bus stays released", a, 0);
    busStop();
    checkRegs("R2 regs unchanged");

    // R4 R5 single-byte at low and high offsets
    byteWrite({1'b1, csBits(), 5'd0}, 8'h3C, "R4 off0");
    byteWrite({1'b1, csBits(), 5'd7}, 8'hA5, "R4 off7");
    byteRead({1'b1, csBits(), 5'd7}, "R5 off7");
    byteRead({1'b1, csBits(), 5'd0}, "R5 off0");

    // R3 wrong chip-select field, then R10 read address refused
    byteWrite({1'b1, 2'b10, 5'd1}, 8'h11, "R3 cs mismatch");
    byteWrite({1'b1, 2'b11, 5'd1}, 8'h12, "R3 cs 11");
    busStart();
    putByte(devAddr() | 8'h01, a); check("R10 read after mismatch", a, 0);
    busStop();
    chipSel = 1'b1;
    byteWrite({1'b1, 2'b01, 5'd2}, 8'h22, "R3 cs1 mismatch");
    byteWrite({1'b1, 2'b10, 5'd2}, 8'h5A, "R3 cs1 match");
    byteRead({1'b1, 2'b10, 5'd2}, "R5 cs1");

    // R2 other address strap
    addrSel = 1'b1;
    busStart();
    putByte(8'hD2, a); check("R2 D2 refused when strap high", a, 0);
    busStop();
    byteWrite({1'b1, csBits(), 5'd3}, 8'h77, "R2 DC write");
    byteRead({1'b1, csBits(), 5'd3}, "R2 DC read");

    // R8 out-of-range offset
    byteWrite({1'b1, csBits(), 5'd20}, 8'h00, "R8 off20");
    byteRead({1'b1, csBits(), 5'd20}, "R8 off20");

    // R6 early stop, R8 block past end
    blockWrite(3, "R6 three");
    blockWrite(10, "R8 ten");
    blockRead(NREG, "R7 full");
    blockRead(3, "R7 short");
    blockRead(10, "R8 read past end");

    // R9 repeated start drops a half-done write
    busStart();
    putByte(devAddr(), a);
    putByte({1'b1, csBits(), 5'd4}, a);
    busStart();
    putByte(devAddr(), a); check("R9 addr after Sr", a, 1);
    putByte({1'b1, csBits(), 5'd5}, a); check("R9 cmd after Sr", a, 1);
    putByte(8'hC3, a); check("R9 data after Sr", a, 1);
    model[5] = 8'hC3;
    busStop();
    checkRegs("R9 regs");

    // random mix
    for (int it = 0; it < 20; it++) begin
      int op;
      logic [4:0] off;
      op = int'($urandom_range(3, 0));
      off = 5'($urandom_range(9, 0));
      case (op)
        0: byteWrite({1'b1, csBits(), off}, 8'($urandom()), "R4 rand");
        1: byteRead({1'b1, csBits(), off}, "R5 rand");
        2: blockWrite(int'($urandom_range(8, 1)), "R6 rand");
        default: blockRead(int'($urandom_range(8, 0)), "R7 rand");
      endcase
    end

    check("R11 sdaOe steady while SCL high", oeViol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule